// File: doc/BRIEF.md
# Camera Receiver Bring-Up Sequencer

This block powers up a serial camera receiver and its D-PHY when a consumer asks for a stream, and powers it down when the last consumer lets go. A start request is counted. Only the first start after an idle period runs the bring-up sequence. Only the stop that releases the last holder runs the teardown. Every other start or stop changes the count and completes in one cycle.

The bring-up writes a rate-select code to the PHY through a separate test-interface master, using a request/acknowledge pair. It then loads the lane-count register and releases the PHY shutdown, PHY reset and controller reset together. Next it asks the sensor to hold its lanes in the low-power stop state and waits until the PHY reports that state. It then asks the sensor to start its clock and waits for a high-speed clock on the clock lane. Both waits are timed against a millisecond tick made by a clock divider.

A missing stop state only raises a warning, and the sequence continues. A missing high-speed clock is an error: the block withdraws the clock request, then the low-power request, and then asserts the resets again.

Top module: `cam_rx_bringup`

States, all named in the `seq_state_t` type:

| State | Action | Leaves to |
|---|---|---|
| ST_IDLE | accepts requests | ST_PHY_WRITE on a first start with good settings; ST_DROP_CLK on the stop that releases the last holder |
| ST_PHY_WRITE | raises the test-interface request | ST_PROGRAM when acknowledged |
| ST_PROGRAM | loads the lane-count register | ST_LP_REQUEST |
| ST_LP_REQUEST | raises the low-power request | ST_WAIT_STOP |
| ST_WAIT_STOP | polls for the stop state | ST_CLK_REQUEST when the stop state is met or the wait times out |
| ST_CLK_REQUEST | raises the sensor clock request | ST_WAIT_HSCLK |
| ST_WAIT_HSCLK | polls for the high-speed clock | ST_IDLE on success; ST_DROP_CLK on timeout |
| ST_DROP_CLK | withdraws the clock request | ST_DROP_LP |
| ST_DROP_LP | withdraws the low-power request | ST_ASSERT_RST |
| ST_ASSERT_RST | asserts the resets | ST_IDLE |

## Requirements
- R1: After reset, the following are all 0: phy_shutdown_n, phy_rst_n, ctrl_rst_n, lane_reg, lp_hold, sensor_clk_req, tst_req, busy, done, warn_stopstate and err_code.
- R2: The rate-select code comes from the first row of the rate table whose limit is strictly greater than the rate. The rate is rate_mbps when rate_valid is 1, and 849 when rate_valid is 0. For example, 849 gives 0x14, 89 gives 0x00, 90 gives 0x20, 300 gives 0x48, 500 gives 0x0e and 999 gives 0x74. The code is sent on tst_data with tst_code = 0x44. A rate of 1000 or more ends the request with err_code 1, with no test write and with the resets still asserted.
- R3: Bring-up runs in this order. First the test write is made. Then lane_reg is loaded with the lane count minus one, and the three reset lines are released in the same cycle. Then lp_hold rises, and after that sensor_clk_req rises.
- R4: The stop state counts as met only when phy_state bit 10 is set and bits 4 through 4+N-1 are all set, where N is the lane count.
- R5: If the stop state is not met within TIMEOUT_MS ticks, warn_stopstate is set and the sequence still goes on to request the clock.
- R6: The high-speed clock counts as present when phy_state bit 8 is set. If it is missing for TIMEOUT_MS ticks, sensor_clk_req falls first, then lp_hold, then the three reset lines, each a cycle apart. The request then completes with err_code 2.
- R7: Hardware bring-up runs only when the hold count goes from 0 to 1, and teardown only when it goes from 1 to 0. Any other start or stop changes the count and leaves the PHY lines unchanged.
- R8: A stop while the count is 0 completes with done, leaves err_code at 0, and leaves the count at 0.
- R9: Start and stop requests that arrive while busy is 1 are ignored.
- R10: A lane count of 0, or one above MAX_LANES, ends a first start with err_code 3, with no test write and with the resets still asserted. A bad rate takes precedence over a bad lane count.
- R11: done is a one-cycle pulse at the completion of every accepted request. An accepted request clears warn_stopstate and err_code from the previous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Stream start request, one cycle |
| stop_req | input | 1 | Stream stop request, one cycle; ignored if start_req is also high |
| lanes_cfg | input | LANE_W | Number of active data lanes |
| rate_valid | input | 1 | rate_mbps is supplied |
| rate_mbps | input | 11 | Per-lane bit rate in Mbps |
| phy_state | input | 16 | PHY state word |
| tst_ack | input | 1 | Test-interface master has completed the write |
| tst_req | output | 1 | Test-interface write request |
| tst_code | output | 8 | Test code of the write |
| tst_data | output | 8 | Rate-select code |
| lane_reg | output | LREG_W | Lane-count register, holding lanes minus one |
| phy_shutdown_n | output | 1 | PHY shutdown, active low |
| phy_rst_n | output | 1 | PHY reset, active low |
| ctrl_rst_n | output | 1 | Controller reset, active low |
| lp_hold | output | 1 | Request to the sensor to hold its lanes in the low-power stop state |
| sensor_clk_req | output | 1 | Request to the sensor to start its clock |
| busy | output | 1 | A sequence is running |
| done | output | 1 | The request has completed |
| warn_stopstate | output | 1 | The stop-state wait timed out |
| err_code | output | 2 | 0 none, 1 rate, 2 clock lane, 3 lane count |

## Verification
The ordering assertions assume that the PHY state word, the test acknowledge and the requests change only between clock edges. They also assume that tst_ack answers a request rather than arriving unasked. The bench keeps to this by driving every input at the falling edge. Its PHY model derives the state word from the block's own reset and request outputs, and it echoes tst_req back as the acknowledge. Requests are single-cycle pulses, and the ignore-while-busy case lengthens the stop-state wait to a full timeout so that the stray pulses land well inside the sequence.

// File: rtl/cam_rx_pkg.sv
package cam_rx_pkg;
    localparam int PHY_STATE_W    = 16;
    localparam int DATA_STOP_LSB  = 4;
    localparam int HS_CLK_BIT     = 8;
    localparam int CLK_STOP_BIT   = 10;
    localparam int RATE_W         = 11;
    localparam int CODE_W         = 8;
    localparam logic [7:0] RATE_TEST_CODE = 8'h44;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PHY_WRITE,
        ST_PROGRAM,
        ST_LP_REQUEST,
        ST_WAIT_STOP,
        ST_CLK_REQUEST,
        ST_WAIT_HSCLK,
        ST_DROP_CLK,
        ST_DROP_LP,
        ST_ASSERT_RST
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_RATE  = 2'd1,
        ERR_HSCLK = 2'd2,
        ERR_LANES = 2'd3
    } seq_err_t;
endpackage

// File: rtl/rate_select_lut.sv
module rate_select_lut
    import cam_rx_pkg::*;
(
    input  logic [RATE_W-1:0] rate_mbps,
    output logic [CODE_W-1:0] code,
    output logic              in_range
);
    localparam int ROWS = 29;

    // limits ascend; the first one above the rate selects the code
    localparam logic [RATE_W-1:0] LIMIT [ROWS] = '{
        11'd90,  11'd100, 11'd110, 11'd125, 11'd140, 11'd150, 11'd160, 11'd180,
        11'd200, 11'd210, 11'd240, 11'd250, 11'd270, 11'd300, 11'd330, 11'd360,
        11'd400, 11'd450, 11'd500, 11'd550, 11'd600, 11'd650, 11'd700, 11'd750,
        11'd800, 11'd850, 11'd900, 11'd950, 11'd1000
    };
    localparam logic [CODE_W-1:0] SEL [ROWS] = '{
        8'h00, 8'h20, 8'h40, 8'h02, 8'h22, 8'h42, 8'h04, 8'h24,
        8'h44, 8'h06, 8'h26, 8'h46, 8'h08, 8'h28, 8'h48, 8'h2a,
        8'h4a, 8'h0c, 8'h2c, 8'h0e, 8'h2e, 8'h10, 8'h30, 8'h12,
        8'h32, 8'h14, 8'h34, 8'h54, 8'h74
    };

    always_comb begin
        code     = '0;
        in_range = 1'b0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (rate_mbps < LIMIT[i]) begin
                code     = SEL[i];
                in_range = 1'b1;
            end
        end
    end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int TICK_DIV   = 250000,
    parameter int TIMEOUT_MS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam int MW = $clog2(TIMEOUT_MS + 1);

    logic [TW-1:0] tick_q;
    logic [MW-1:0] ms_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            ms_q   <= '0;
        end else if (clear) begin
            tick_q <= '0;
            ms_q   <= '0;
        end else if (tick_q == TW'(TICK_DIV - 1)) begin
            tick_q <= '0;
            if (ms_q != MW'(TIMEOUT_MS))
                ms_q <= ms_q + 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign expired = (ms_q == MW'(TIMEOUT_MS));

    // R5: a cleared timer cannot report expiry on the following cycle
    a_r5_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !expired);
endmodule

// File: rtl/hold_counter.sv
module hold_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (inc && cnt_q != {CNT_W{1'b1}})
            cnt_q <= cnt_q + 1'b1;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign count = cnt_q;

    // R7: the hold count moves by one step at most per cycle
    a_r7_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |->
            (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cam_rx_bringup.sv
module cam_rx_bringup
    import cam_rx_pkg::*;
#(
    parameter int MAX_LANES    = 4,
    parameter int DEFAULT_MBPS = 849,
    parameter int TICK_DIV     = 250000,
    parameter int TIMEOUT_MS   = 500,
    parameter int CNT_W        = 4,
    localparam int LANE_W      = $clog2(MAX_LANES + 1),
    localparam int LREG_W      = (MAX_LANES > 2) ? $clog2(MAX_LANES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_req,
    input  logic                   stop_req,
    input  logic [LANE_W-1:0]      lanes_cfg,
    input  logic                   rate_valid,
    input  logic [RATE_W-1:0]      rate_mbps,
    input  logic [PHY_STATE_W-1:0] phy_state,
    input  logic                   tst_ack,
    output logic                   tst_req,
    output logic [7:0]             tst_code,
    output logic [CODE_W-1:0]      tst_data,
    output logic [LREG_W-1:0]      lane_reg,
    output logic                   phy_shutdown_n,
    output logic                   phy_rst_n,
    output logic                   ctrl_rst_n,
    output logic                   lp_hold,
    output logic                   sensor_clk_req,
    output logic                   busy,
    output logic                   done,
    output logic                   warn_stopstate,
    output logic [1:0]             err_code
);
    seq_state_t state_q, state_d;

    logic [RATE_W-1:0]      eff_rate;
    logic [CODE_W-1:0]      rate_code;
    logic                   rate_ok;
    logic                   lanes_ok;
    logic [CNT_W-1:0]       count;
    logic                   cnt_zero, cnt_one;
    logic                   stop_only;
    logic                   expired, timer_clear;
    logic [PHY_STATE_W-1:0] stop_mask;
    logic                   stop_met, hs_clk;
    logic                   cnt_inc, cnt_dec;

    logic [CODE_W-1:0]      code_q;
    logic [LANE_W-1:0]      lanes_q;
    logic [LREG_W-1:0]      lane_reg_q;
    logic                   hw_en_q, lp_q, clkreq_q, done_q, warn_q, fail_q;
    seq_err_t               err_q;

    assign eff_rate  = rate_valid ? rate_mbps : RATE_W'(DEFAULT_MBPS);
    assign lanes_ok  = (lanes_cfg != '0) && (lanes_cfg <= LANE_W'(MAX_LANES));
    assign cnt_zero  = (count == '0);
    assign cnt_one   = (count == CNT_W'(1));
    assign stop_only = stop_req && !start_req;

    rate_select_lut u_rate (
        .rate_mbps (eff_rate),
        .code      (rate_code),
        .in_range  (rate_ok)
    );

    poll_timer #(.TICK_DIV(TICK_DIV), .TIMEOUT_MS(TIMEOUT_MS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .expired (expired)
    );

    hold_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .dec   (cnt_dec),
        .count (count)
    );

    // stop state: clock lane plus every active data lane
    always_comb begin
        stop_mask = '0;
        stop_mask[CLK_STOP_BIT] = 1'b1;
        for (int i = 0; i < MAX_LANES; i++) begin
            if (LANE_W'(i) < lanes_q)
                stop_mask[DATA_STOP_LSB + i] = 1'b1;
        end
    end

    assign stop_met    = ((phy_state & stop_mask) == stop_mask);
    assign hs_clk      = phy_state[HS_CLK_BIT];
    assign timer_clear = !(state_q == ST_WAIT_STOP || state_q == ST_WAIT_HSCLK);

    assign cnt_inc = (state_q == ST_IDLE && start_req && !cnt_zero) ||
                     (state_q == ST_WAIT_HSCLK && hs_clk);
    assign cnt_dec = (state_q == ST_IDLE && stop_only && !cnt_one) ||
                     (state_q == ST_ASSERT_RST && !fail_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req && cnt_zero && rate_ok && lanes_ok)
                    state_d = ST_PHY_WRITE;
                else if (stop_only && cnt_one)
                    state_d = ST_DROP_CLK;
            end
            ST_PHY_WRITE:   if (tst_ack) state_d = ST_PROGRAM;
            ST_PROGRAM:     state_d = ST_LP_REQUEST;
            ST_LP_REQUEST:  state_d = ST_WAIT_STOP;
            ST_WAIT_STOP:   if (stop_met || expired) state_d = ST_CLK_REQUEST;
            ST_CLK_REQUEST: state_d = ST_WAIT_HSCLK;
            ST_WAIT_HSCLK: begin
                if (hs_clk)       state_d = ST_IDLE;
                else if (expired) state_d = ST_DROP_CLK;
            end
            ST_DROP_CLK:    state_d = ST_DROP_LP;
            ST_DROP_LP:     state_d = ST_ASSERT_RST;
            ST_ASSERT_RST:  state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q     <= '0;
            lanes_q    <= '0;
            lane_reg_q <= '0;
            hw_en_q    <= 1'b0;
            lp_q       <= 1'b0;
            clkreq_q   <= 1'b0;
            done_q     <= 1'b0;
            warn_q     <= 1'b0;
            fail_q     <= 1'b0;
            err_q      <= ERR_NONE;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        err_q  <= ERR_NONE;
                        warn_q <= 1'b0;
                        fail_q <= 1'b0;
                        if (!cnt_zero) begin
                            done_q <= 1'b1;
                        end else if (!rate_ok) begin
                            err_q  <= ERR_RATE;
                            done_q <= 1'b1;
                        end else if (!lanes_ok) begin
                            err_q  <= ERR_LANES;
                            done_q <= 1'b1;
                        end else begin
                            code_q  <= rate_code;
                            lanes_q <= lanes_cfg;
                        end
                    end else if (stop_req) begin
                        err_q  <= ERR_NONE;
                        warn_q <= 1'b0;
                        fail_q <= 1'b0;
                        if (!cnt_one)
                            done_q <= 1'b1;
                    end
                end
                ST_PROGRAM: begin
                    lane_reg_q <= LREG_W'(lanes_q - 1'b1);
                    hw_en_q    <= 1'b1;
                end
                ST_LP_REQUEST:  lp_q <= 1'b1;
                ST_WAIT_STOP:   if (!stop_met && expired) warn_q <= 1'b1;
                ST_CLK_REQUEST: clkreq_q <= 1'b1;
                ST_WAIT_HSCLK: begin
                    if (hs_clk)       done_q <= 1'b1;
                    else if (expired) fail_q <= 1'b1;
                end
                ST_DROP_CLK:    clkreq_q <= 1'b0;
                ST_DROP_LP:     lp_q <= 1'b0;
                ST_ASSERT_RST: begin
                    hw_en_q <= 1'b0;
                    done_q  <= 1'b1;
                    if (fail_q) err_q <= ERR_HSCLK;
                end
                default: ;
            endcase
        end
    end

    assign tst_req        = (state_q == ST_PHY_WRITE);
    assign tst_code       = RATE_TEST_CODE;
    assign tst_data       = code_q;
    assign lane_reg       = lane_reg_q;
    assign phy_shutdown_n = hw_en_q;
    assign phy_rst_n      = hw_en_q;
    assign ctrl_rst_n     = hw_en_q;
    assign lp_hold        = lp_q;
    assign sensor_clk_req = clkreq_q;
    assign busy           = (state_q != ST_IDLE);
    assign done           = done_q;
    assign warn_stopstate = warn_q;
    assign err_code       = err_q;

    // R3: resets are released before either sensor request exists
    a_r3_release_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hw_en_q) |-> (!lp_q && !clkreq_q));
    // R3: the low-power request only rises with the PHY out of reset
    a_r3_lp_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_q) |-> hw_en_q);
    // R3: the clock request needs both the release and the low-power request
    a_r3_clk_needs_lp: assert property (@(posedge clk) disable iff (!rst_n)
        clkreq_q |-> (hw_en_q && lp_q));
    // R6: unwinding drops the clock request before the low-power request
    a_r6_clk_drops_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lp_q) |-> !clkreq_q);
    // R6: resets are asserted last
    a_r6_reset_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hw_en_q) |-> (!lp_q && !clkreq_q));
    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R9: a request seen while busy leaves the hold count unchanged
    a_r9_busy_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_WAIT_HSCLK && state_q != ST_ASSERT_RST) |=> $stable(count));
endmodule

// File: tb/test_cam_rx_bringup.sv
module test_cam_rx_bringup;
    localparam int MAX_LANES = 4;
    localparam int LANE_W    = 3;
    localparam int LREG_W    = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0, stop_req = 1'b0;
    logic [2:0]  lanes_cfg = 3'd1;
    logic        rate_valid = 1'b0;
    logic [10:0] rate_mbps = '0;
    logic [15:0] phy_state = '0;
    logic        tst_ack = 1'b0;
    logic        tst_req;
    logic [7:0]  tst_code, tst_data;
    logic [1:0]  lane_reg;
    logic        phy_shutdown_n, phy_rst_n, ctrl_rst_n, lp_hold, sensor_clk_req;
    logic        busy, done, warn_stopstate;
    logic [1:0]  err_code;

    int n_checks = 0, n_fail = 0;

    always #2 clk = ~clk;

    cam_rx_bringup #(.MAX_LANES(MAX_LANES), .TICK_DIV(20), .TIMEOUT_MS(5)) i_cam_rx_bringup (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .lanes_cfg(lanes_cfg), .rate_valid(rate_valid), .rate_mbps(rate_mbps),
        .phy_state(phy_state), .tst_ack(tst_ack), .tst_req(tst_req),
        .tst_code(tst_code), .tst_data(tst_data), .lane_reg(lane_reg),
        .phy_shutdown_n(phy_shutdown_n), .phy_rst_n(phy_rst_n), .ctrl_rst_n(ctrl_rst_n),
        .lp_hold(lp_hold), .sensor_clk_req(sensor_clk_req), .busy(busy), .done(done),
        .warn_stopstate(warn_stopstate), .err_code(err_code)
    );

    // PHY / test-master model, updated away from the active edge
    int  m_stop_lanes = 4;
    bit  m_clk_stop = 1, m_clk_ok = 1;
    int  wr_count = 0;
    int  last_code = 0, last_tcode = 0;
    int  cyc = 0;
    int  t_wr, t_rel, t_lp, t_clk, f_clk, f_lp, f_rst;
    bit  p_tst = 0, p_rel = 0, p_lp = 0, p_clk = 0;

    always @(negedge clk) begin
        logic [15:0] ps;
        cyc++;
        ps = '0;
        if (phy_rst_n) begin
            ps[10] = m_clk_stop;
            for (int i = 0; i < MAX_LANES; i++)
                if (i < m_stop_lanes) ps[4 + i] = 1'b1;
        end
        if (sensor_clk_req && m_clk_ok) ps[8] = 1'b1;
        phy_state = ps;
        tst_ack = tst_req;
        if (tst_req && !p_tst) begin
            wr_count++; last_code = tst_data; last_tcode = tst_code; t_wr = cyc;
        end
        if (phy_rst_n && !p_rel) t_rel = cyc;
        if (!phy_rst_n && p_rel) f_rst = cyc;
        if (lp_hold && !p_lp) t_lp = cyc;
        if (!lp_hold && p_lp) f_lp = cyc;
        if (sensor_clk_req && !p_clk) t_clk = cyc;
        if (!sensor_clk_req && p_clk) f_clk = cyc;
        p_tst = tst_req; p_rel = phy_rst_n; p_lp = lp_hold; p_clk = sensor_clk_req;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input bit is_start);
        @(negedge clk);
        if (is_start) start_req = 1'b1; else stop_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0; stop_req = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk); n++;
        end
        check({tag, " done seen"}, int'(done), 1);
        @(negedge clk);
        check("R11 done one cycle", int'(done), 0);
    endtask

    task automatic clear_marks();
        t_wr = -1; t_rel = -1; t_lp = -1; t_clk = -1; f_clk = -1; f_lp = -1; f_rst = -1;
    endtask

    typedef struct packed {
        logic        rv;
        logic [10:0] rate;
        logic [2:0]  lanes;
        logic [2:0]  stop_lanes;
        logic        clk_stop;
        logic        clk_ok;
        logic [1:0]  err;
        logic        warn;
        logic [7:0]  code;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 11'd1000, 3'd2, 3'd2, 1'b1, 1'b1, 2'd0, 1'b0, 8'h14},
        '{1'b1, 11'd89,   3'd1, 3'd1, 1'b1, 1'b1, 2'd0, 1'b0, 8'h00},
        '{1'b1, 11'd90,   3'd4, 3'd4, 1'b1, 1'b1, 2'd0, 1'b0, 8'h20},
        '{1'b1, 11'd999,  3'd3, 3'd2, 1'b1, 1'b1, 2'd0, 1'b1, 8'h74},
        '{1'b1, 11'd1000, 3'd2, 3'd2, 1'b1, 1'b1, 2'd1, 1'b0, 8'h00},
        '{1'b1, 11'd500,  3'd2, 3'd2, 1'b1, 1'b0, 2'd2, 1'b0, 8'h0e},
        '{1'b1, 11'd300,  3'd0, 3'd0, 1'b1, 1'b1, 2'd3, 1'b0, 8'h00},
        '{1'b1, 11'd300,  3'd5, 3'd4, 1'b1, 1'b1, 2'd3, 1'b0, 8'h00},
        '{1'b1, 11'd300,  3'd4, 3'd4, 1'b0, 1'b1, 2'd0, 1'b1, 8'h48}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int wr0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 shutdown_n", int'(phy_shutdown_n), 0);
        check("R1 phy_rst_n", int'(phy_rst_n), 0);
        check("R1 ctrl_rst_n", int'(ctrl_rst_n), 0);
        check("R1 lp/clk/tst", int'({lp_hold, sensor_clk_req, tst_req}), 0);
        check("R1 busy/done/warn/err", int'({busy, done, warn_stopstate, err_code}), 0);
        check("R1 lane_reg", int'(lane_reg), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            vec_t x;
            string tag;
            x = VECS[v];
            tag = (x.err == 2'd1) ? "R2" : (x.err == 2'd2) ? "R6" : (x.err == 2'd3) ? "R10" : "R3";
            m_stop_lanes = int'(x.stop_lanes); m_clk_stop = x.clk_stop; m_clk_ok = x.clk_ok;
            rate_valid = x.rv; rate_mbps = x.rate; lanes_cfg = x.lanes;
            wr0 = wr_count;
            clear_marks();
            pulse(1'b1);
            wait_done(tag);
            check({tag, " err_code"}, int'(err_code), int'(x.err));
            check("R4 R5 warn_stopstate", int'(warn_stopstate), int'(x.warn));
            if (x.err == 2'd1 || x.err == 2'd3) begin
                check({tag, " no test write"}, wr_count - wr0, 0);
                check({tag, " resets held"}, int'(phy_rst_n), 0);
            end else begin
                check("R2 rate code", last_code, int'(x.code));
                check("R2 test code", last_tcode, 'h44);
                check("R3 write before release", int'(t_wr < t_rel && t_wr > 0), 1);
                check("R3 release before lp", int'(t_rel < t_lp), 1);
                check("R3 lp before clock request", int'(t_lp < t_clk), 1);
                check("R3 lane_reg", int'(lane_reg), int'(x.lanes) - 1);
            end
            if (x.err == 2'd0) begin
                check("R3 lines released", int'({phy_shutdown_n, phy_rst_n, ctrl_rst_n, sensor_clk_req}), 'hf);
                pulse(1'b0);
                wait_done("R7 teardown");
                check("R7 teardown resets", int'({phy_shutdown_n, phy_rst_n, ctrl_rst_n}), 0);
                check("R7 teardown order", int'(f_clk < f_lp && f_lp < f_rst && f_clk > 0), 1);
            end
            if (x.err == 2'd2) begin
                check("R6 unwind order", int'(f_clk < f_lp && f_lp < f_rst && f_clk > 0), 1);
                check("R6 all lines low", int'({phy_rst_n, lp_hold, sensor_clk_req}), 0);
            end
        end

        // R7: reference counting
        m_stop_lanes = 4; m_clk_stop = 1; m_clk_ok = 1;
        rate_valid = 1'b0; lanes_cfg = 3'd4;
        pulse(1'b1); wait_done("R7 first start");
        wr0 = wr_count;
        pulse(1'b1); wait_done("R7 second start");
        check("R7 no second write", wr_count - wr0, 0);
        pulse(1'b0); wait_done("R7 first stop");
        check("R7 still up after one stop", int'(phy_rst_n), 1);
        pulse(1'b0); wait_done("R7 last stop");
        check("R7 down after last stop", int'(phy_rst_n), 0);

        // R8: stop at zero saturates
        pulse(1'b0); wait_done("R8 stop at zero");
        check("R8 err stays 0", int'(err_code), 0);
        check("R8 resets stay asserted", int'(phy_rst_n), 0);
        wr0 = wr_count;
        pulse(1'b1); wait_done("R8 start after saturation");
        check("R8 count was zero", wr_count - wr0, 1);
        pulse(1'b0); wait_done("R8 cleanup");

        // R11: error cleared by next accepted request
        rate_valid = 1'b1; rate_mbps = 11'd1500;
        pulse(1'b1); wait_done("R11 error start");
        check("R11 error reported", int'(err_code), 1);
        rate_valid = 1'b0;
        pulse(1'b1); wait_done("R11 good start");
        check("R11 error cleared", int'(err_code), 0);
        pulse(1'b0); wait_done("R11 cleanup");

        // R9: requests while busy are ignored
        m_stop_lanes = 0;
        wr0 = wr_count;
        pulse(1'b1);
        check("R9 busy", int'(busy), 1);
        pulse(1'b0);
        pulse(1'b1);
        wait_done("R9 start");
        check("R9 one write", wr_count - wr0, 1);
        check("R9 up", int'(phy_rst_n), 1);
        check("R5 warn on timeout", int'(warn_stopstate), 1);
        pulse(1'b0); wait_done("R9 single stop");
        check("R9 count was one", int'(phy_rst_n), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule